// File: doc/BRIEF.md
# Character-Row CRT Timing Generator

This block produces the raster timing for a character-cell video display. It counts in character times along a line, scan lines within a character row, and character rows within a frame. A programmable run of extra scan lines may follow the last row before the frame starts again. From these counts it drives horizontal and vertical sync, a display-enable window, the refresh memory address of the current character and the scan line inside the current row. It also drives a cursor strobe while the refresh address equals a programmed cursor address, limited to a band of scan lines.

Software configures the block through two byte-wide locations. `bus_sel` = 0 selects the index location and `bus_sel` = 1 selects the data window onto the register that the index names. `bus_rdata` is combinational from `bus_sel` and the stored index, and a write takes effect at the rising edge while `bus_wr` is high. The block has no streaming data path, so every pin is a plain level signal with no handshake. One `clk` cycle is one character time. A value N stored in a count register means N+1 units, except for the extra-line count, which means exactly N lines.

Top module: `crt_timing_ctrl`

## Requirements
- R1: A write with bus_sel=0 stores bus_wdata[4:0] as the index. A write with bus_sel=1 stores bus_wdata into the indexed register when the index is 0..15, and a read with bus_sel=1 returns that stored byte.
- R2: Indices 16, 17 (light pen, out of scope) and 18..31 read as 0 with bus_sel=1, and writes to them are ignored.
- R3: A read with bus_sel=0 returns the index in bits 4:0 and the vertical-blank flag in bit 5. Bits 7:6 read 0.
- R4: A line lasts reg0+1 clocks, and h counts 0..reg0. disp_en is high only when h <= reg1, the row is <= reg6, and the block is not in the extra-line phase.
- R5: hsync is high when h >= reg2 and h-reg2 < W, where W = reg3[3:0] and 0 means 16. The pulse is cut off at the end of the line.
- R6: A frame has reg4+1 rows of reg9[4:0]+1 scan lines each, followed by reg5[4:0] extra lines. row_addr gives the scan line within the row. During the extra lines it counts 0..reg5-1.
- R7: vsync rises on the first clock of scan line 0 of row reg7 and stays high for W scan lines, where W = reg3[7:4] and 0 means 16. The pulse may continue across the frame boundary.
- R8: mem_addr = (S + r*(reg1+1) + h) mod 2^14. S is the 14 low bits of {reg12,reg13}. r is the row number, or reg4+1 during the extra lines.
- R9: cursor is high exactly when disp_en is high, mem_addr equals the 14 low bits of {reg14,reg15}, and reg10[4:0] <= row_addr <= reg11[4:0].
- R10: The vertical-blank flag is high when the row exceeds reg6 or the block is in the extra-line phase. It is never high together with disp_en.
- R11: After reset the index and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the index location, 1 selects the data window |
| bus_wr | input | 1 | Write strobe for the selected location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Display-enable window |
| mem_addr | output | 14 | Refresh memory address |
| row_addr | output | 5 | Scan line within the character row |
| cursor | output | 1 | Cursor strobe |

## Verification
The hardest states to reach from the ports are those where one frame's state carries into the next. Examples are a vertical sync pulse that is still running when the frame wraps, a refresh address that rolls past 2^14 mid-row, and a row-start address that steps into the extra-line phase. Each sweep programs all sixteen registers and then waits for two rising edges of vsync, so that both a frame wrap and a sync load have happened under the new settings. It then compares every output on every clock for two whole frames against positions derived arithmetically from the elapsed clock count. The three configurations cover a wrapping start address, zero sync widths that mean 16, a sync pulse that crosses the frame end, a zero-length extra phase, and one-line rows.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CRTC_DW     = 8;
  localparam int CRTC_PTR_W  = 5;
  localparam int CRTC_NSTORE = 16;
  localparam int CRTC_RA_W   = 5;
  localparam int CRTC_MA_W   = 14;
  localparam int CRTC_STAT_VB = 5;

  localparam int IX_HTOT   = 0;
  localparam int IX_HDISP  = 1;
  localparam int IX_HSPOS  = 2;
  localparam int IX_SYNCW  = 3;
  localparam int IX_VTOT   = 4;
  localparam int IX_VADJ   = 5;
  localparam int IX_VDISP  = 6;
  localparam int IX_VSROW  = 7;
  localparam int IX_MAXSL  = 9;
  localparam int IX_CFIRST = 10;
  localparam int IX_CLAST  = 11;
  localparam int IX_STHI   = 12;
  localparam int IX_STLO   = 13;
  localparam int IX_CUHI   = 14;
  localparam int IX_CULO   = 15;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int PTR_W  = CRTC_PTR_W,
  parameter int DW     = CRTC_DW,
  parameter int NSTORE = CRTC_NSTORE,
  parameter int RA_W   = CRTC_RA_W,
  parameter int MA_W   = CRTC_MA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             vblank,
  output logic [DW-1:0]    bus_rdata,
  output logic [DW-1:0]    c_htot,
  output logic [DW-1:0]    c_hdisp,
  output logic [DW-1:0]    c_hs_pos,
  output logic [3:0]       c_hs_wid,
  output logic [3:0]       c_vs_wid,
  output logic [DW-1:0]    c_vtot,
  output logic [RA_W-1:0]  c_vadj,
  output logic [DW-1:0]    c_vdisp,
  output logic [DW-1:0]    c_vs_row,
  output logic [RA_W-1:0]  c_max_sl,
  output logic [RA_W-1:0]  c_cur_first,
  output logic [RA_W-1:0]  c_cur_last,
  output logic [MA_W-1:0]  c_start,
  output logic [MA_W-1:0]  c_curs
);
  localparam int IW = $clog2(NSTORE);

  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    regs_q [NSTORE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (!bus_sel && bus_wr) ptr_q <= bus_wdata[PTR_W-1:0];
  end

  for (genvar gi = 0; gi < NSTORE; gi++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[gi] <= '0;
      else if (bus_sel && bus_wr && (ptr_q == PTR_W'(gi)))
        regs_q[gi] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_sel) begin
      bus_rdata[PTR_W-1:0]    = ptr_q;
      bus_rdata[CRTC_STAT_VB] = vblank;
    end else if (ptr_q < PTR_W'(NSTORE)) begin
      bus_rdata = regs_q[ptr_q[IW-1:0]];
    end
  end

  assign c_htot      = regs_q[IX_HTOT];
  assign c_hdisp     = regs_q[IX_HDISP];
  assign c_hs_pos    = regs_q[IX_HSPOS];
  assign c_hs_wid    = regs_q[IX_SYNCW][3:0];
  assign c_vs_wid    = regs_q[IX_SYNCW][7:4];
  assign c_vtot      = regs_q[IX_VTOT];
  assign c_vadj      = regs_q[IX_VADJ][RA_W-1:0];
  assign c_vdisp     = regs_q[IX_VDISP];
  assign c_vs_row    = regs_q[IX_VSROW];
  assign c_max_sl    = regs_q[IX_MAXSL][RA_W-1:0];
  assign c_cur_first = regs_q[IX_CFIRST][RA_W-1:0];
  assign c_cur_last  = regs_q[IX_CLAST][RA_W-1:0];
  assign c_start     = MA_W'({regs_q[IX_STHI], regs_q[IX_STLO]});
  assign c_curs      = MA_W'({regs_q[IX_CUHI], regs_q[IX_CULO]});
endmodule

// File: rtl/crtc_raster.sv
module crtc_raster
  import crtc_pkg::*;
#(
  parameter int DW   = CRTC_DW,
  parameter int RA_W = CRTC_RA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   htot,
  input  logic [DW-1:0]   hdisp,
  input  logic [DW-1:0]   hs_pos,
  input  logic [3:0]      hs_wid,
  input  logic [3:0]      vs_wid,
  input  logic [DW-1:0]   vtot,
  input  logic [RA_W-1:0] vadj,
  input  logic [DW-1:0]   vdisp,
  input  logic [DW-1:0]   vs_row,
  input  logic [RA_W-1:0] max_sl,
  output logic [DW-1:0]   h_cnt,
  output logic [DW-1:0]   v_row,
  output logic [RA_W-1:0] v_sl,
  output logic            row_end,
  output logic            frame_wrap,
  output logic            hsync,
  output logic            vsync,
  output logic            disp_en,
  output logic            vblank
);
  localparam int SW_W = 5;

  logic            in_adj;
  logic            line_end, sl_last, row_last, adj_last, enter_adj, vs_hit;
  logic [SW_W-1:0] vs_left, vs_load, hs_w;
  logic [DW-1:0]   hs_off;

  assign line_end  = (h_cnt >= htot);
  assign sl_last   = (v_sl >= max_sl);
  assign row_last  = (v_row >= vtot);
  assign adj_last  = ({1'b0, v_sl} + 1'b1) >= {1'b0, vadj};
  assign row_end   = line_end && !in_adj && sl_last;
  assign enter_adj = row_end && row_last && (vadj != '0);
  assign frame_wrap = line_end && (in_adj ? adj_last
                                          : (sl_last && row_last && (vadj == '0)));
  assign vs_hit = (frame_wrap && (vs_row == '0)) ||
                  (row_end && !row_last && (({1'b0, v_row} + 1'b1) == {1'b0, vs_row}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        h_cnt <= '0;
    else if (line_end) h_cnt <= '0;
    else               h_cnt <= h_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_row  <= '0;
      v_sl   <= '0;
      in_adj <= 1'b0;
    end else if (line_end) begin
      if (frame_wrap) begin
        v_row  <= '0;
        v_sl   <= '0;
        in_adj <= 1'b0;
      end else if (enter_adj) begin
        v_sl   <= '0;
        in_adj <= 1'b1;
      end else if (row_end) begin
        v_row <= v_row + 1'b1;
        v_sl  <= '0;
      end else begin
        v_sl <= v_sl + 1'b1;
      end
    end
  end

  assign vs_load = (vs_wid == 4'd0) ? SW_W'(16) : SW_W'(vs_wid);
  assign hs_w    = (hs_wid == 4'd0) ? SW_W'(16) : SW_W'(hs_wid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         vs_left <= '0;
    else if (vs_hit)                    vs_left <= vs_load;
    else if (line_end && vs_left != '0) vs_left <= vs_left - 1'b1;
  end

  assign hs_off  = h_cnt - hs_pos;
  assign hsync   = (h_cnt >= hs_pos) && (hs_off < DW'(hs_w));
  assign vsync   = (vs_left != '0);
  assign vblank  = in_adj || (v_row > vdisp);
  assign disp_en = !vblank && (h_cnt <= hdisp);
endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen
  import crtc_pkg::*;
#(
  parameter int DW   = CRTC_DW,
  parameter int RA_W = CRTC_RA_W,
  parameter int MA_W = CRTC_MA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   hdisp,
  input  logic [MA_W-1:0] start,
  input  logic [MA_W-1:0] curs,
  input  logic [RA_W-1:0] cur_first,
  input  logic [RA_W-1:0] cur_last,
  input  logic [DW-1:0]   h_cnt,
  input  logic [RA_W-1:0] v_sl,
  input  logic            row_end,
  input  logic            frame_wrap,
  input  logic            disp_en,
  output logic [MA_W-1:0] mem_addr,
  output logic            cursor
);
  logic [MA_W-1:0] row_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          row_start <= '0;
    else if (frame_wrap) row_start <= start;
    else if (row_end)    row_start <= row_start + MA_W'(hdisp) + 1'b1;
  end

  assign mem_addr = row_start + MA_W'(h_cnt);
  assign cursor   = disp_en && (mem_addr == curs) &&
                    (v_sl >= cur_first) && (v_sl <= cur_last);
endmodule

// File: rtl/crt_timing_ctrl.sv
module crt_timing_ctrl
  import crtc_pkg::*;
#(
  parameter int DW   = CRTC_DW,
  parameter int RA_W = CRTC_RA_W,
  parameter int MA_W = CRTC_MA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            hsync,
  output logic            vsync,
  output logic            disp_en,
  output logic [MA_W-1:0] mem_addr,
  output logic [RA_W-1:0] row_addr,
  output logic            cursor
);
  logic [DW-1:0]   cfg_htot, cfg_hdisp, cfg_hs_pos, cfg_vtot, cfg_vdisp, cfg_vs_row;
  logic [3:0]      cfg_hs_wid, cfg_vs_wid;
  logic [RA_W-1:0] cfg_vadj, cfg_max_sl, cfg_cur_first, cfg_cur_last;
  logic [MA_W-1:0] cfg_start, cfg_curs;
  logic [DW-1:0]   h_cnt, v_row;
  logic [RA_W-1:0] v_sl;
  logic            row_end, frame_wrap, vblank;

  crtc_regfile #(.PTR_W(CRTC_PTR_W), .DW(DW), .NSTORE(CRTC_NSTORE), .RA_W(RA_W), .MA_W(MA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .vblank(vblank), .bus_rdata(bus_rdata),
    .c_htot(cfg_htot), .c_hdisp(cfg_hdisp), .c_hs_pos(cfg_hs_pos),
    .c_hs_wid(cfg_hs_wid), .c_vs_wid(cfg_vs_wid), .c_vtot(cfg_vtot),
    .c_vadj(cfg_vadj), .c_vdisp(cfg_vdisp), .c_vs_row(cfg_vs_row),
    .c_max_sl(cfg_max_sl), .c_cur_first(cfg_cur_first), .c_cur_last(cfg_cur_last),
    .c_start(cfg_start), .c_curs(cfg_curs)
  );

  crtc_raster #(.DW(DW), .RA_W(RA_W)) u_raster (
    .clk(clk), .rst_n(rst_n), .htot(cfg_htot), .hdisp(cfg_hdisp),
    .hs_pos(cfg_hs_pos), .hs_wid(cfg_hs_wid), .vs_wid(cfg_vs_wid),
    .vtot(cfg_vtot), .vadj(cfg_vadj), .vdisp(cfg_vdisp), .vs_row(cfg_vs_row),
    .max_sl(cfg_max_sl), .h_cnt(h_cnt), .v_row(v_row), .v_sl(v_sl),
    .row_end(row_end), .frame_wrap(frame_wrap), .hsync(hsync), .vsync(vsync),
    .disp_en(disp_en), .vblank(vblank)
  );

  crtc_addr_gen #(.DW(DW), .RA_W(RA_W), .MA_W(MA_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .hdisp(cfg_hdisp), .start(cfg_start),
    .curs(cfg_curs), .cur_first(cfg_cur_first), .cur_last(cfg_cur_last),
    .h_cnt(h_cnt), .v_sl(v_sl), .row_end(row_end), .frame_wrap(frame_wrap),
    .disp_en(disp_en), .mem_addr(mem_addr), .cursor(cursor)
  );

  assign row_addr = v_sl;
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
  parameter int DW   = 8,
  parameter int RA_W = 5,
  parameter int MA_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hsync,
  input logic            vsync,
  input logic            disp_en,
  input logic            cursor,
  input logic            vblank,
  input logic [MA_W-1:0] mem_addr,
  input logic [RA_W-1:0] row_addr,
  input logic [DW-1:0]   h_cnt,
  input logic [DW-1:0]   v_row,
  input logic [RA_W-1:0] v_sl,
  input logic [DW-1:0]   cfg_hs_pos,
  input logic [DW-1:0]   cfg_vs_row
);
  p_de_not_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !vblank);

  p_cursor_needs_de_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cursor |-> disp_en);

  p_hsync_after_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> (h_cnt >= cfg_hs_pos));

  p_rowaddr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0) |-> (row_addr == $past(row_addr)));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0) |-> (mem_addr == MA_W'($past(mem_addr) + MA_W'(1))));

  p_vsync_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (h_cnt == '0 && v_sl == '0 && v_row == cfg_vs_row));
endmodule

bind crt_timing_ctrl crtc_timing_chk #(.DW(DW), .RA_W(RA_W), .MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
  .cursor(cursor), .vblank(vblank), .mem_addr(mem_addr), .row_addr(row_addr),
  .h_cnt(h_cnt), .v_row(v_row), .v_sl(v_sl), .cfg_hs_pos(cfg_hs_pos),
  .cfg_vs_row(cfg_vs_row)
);

// File: tb/crt_timing_ctrl_tb.sv
`timescale 1ns/1ps
module crt_timing_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       hsync, vsync, disp_en, cursor;
  logic [13:0] mem_addr;
  logic [4:0]  row_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cr [16];

  always #2 clk = ~clk;

  crt_timing_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync), .vsync(vsync),
    .disp_en(disp_en), .mem_addr(mem_addr), .row_addr(row_addr), .cursor(cursor)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit sel, input int data);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = 8'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic write_reg(input int idx, input int val);
    bus_write(1'b0, idx);
    bus_write(1'b1, val);
  endtask

  task automatic read_reg(input int idx, output int v);
    bus_write(1'b0, idx);
    @(negedge clk);
    bus_sel = 1'b1;
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_vs_rise();
    bit prev;
    prev = vsync;
    forever begin
      @(negedge clk);
      #1;
      if (vsync && !prev) break;
      prev = vsync;
    end
  endtask

  task automatic sweep(input string name);
    int hh, msl1, rows_l, adj, ff, vw, hw, vline, st, cu, hdisp1;
    for (int i = 0; i < 16; i++) write_reg(i, cr[i]);
    @(negedge clk);
    bus_sel = 1'b0;
    hh     = cr[0] + 1;
    hdisp1 = cr[1] + 1;
    msl1   = (cr[9] & 31) + 1;
    rows_l = (cr[4] + 1) * msl1;
    adj    = cr[5] & 31;
    ff     = rows_l + adj;
    hw     = ((cr[3] & 15) == 0) ? 16 : (cr[3] & 15);
    vw     = ((cr[3] >> 4) == 0) ? 16 : (cr[3] >> 4);
    vline  = cr[7] * msl1;
    st     = ((cr[12] << 8) | cr[13]) & 16'h3FFF;
    cu     = ((cr[14] << 8) | cr[15]) & 16'h3FFF;
    wait_vs_rise();
    wait_vs_rise();
    for (int t = 0; t < 2 * ff * hh; t++) begin
      int pos, line, h, row, sl, rowa, e_mem, ld;
      bit inadj, e_de, e_hs, e_vs, e_cur, e_vb;
      pos  = (vline * hh + t) % (ff * hh);
      line = pos / hh;
      h    = pos % hh;
      inadj = (line >= rows_l);
      row  = inadj ? cr[4] : line / msl1;
      sl   = inadj ? line - rows_l : line % msl1;
      rowa = inadj ? cr[4] + 1 : row;
      e_vb = inadj || (row > cr[6]);
      e_de = !e_vb && (h <= cr[1]);
      e_hs = (h >= cr[2]) && (h - cr[2] < hw);
      ld   = (line - vline + ff) % ff;
      e_vs = (ld < vw);
      e_mem = (st + rowa * hdisp1 + h) & 16'h3FFF;
      e_cur = e_de && (e_mem == cu) && (sl >= (cr[10] & 31)) && (sl <= (cr[11] & 31));
      chk(disp_en == e_de, {name, " R4 disp_en"}, int'(disp_en), int'(e_de));
      chk(hsync == e_hs, {name, " R5 hsync"}, int'(hsync), int'(e_hs));
      chk(row_addr == 5'(sl), {name, " R6 row_addr"}, int'(row_addr), sl);
      chk(vsync == e_vs, {name, " R7 vsync"}, int'(vsync), int'(e_vs));
      chk(mem_addr == 14'(e_mem), {name, " R8 mem_addr"}, int'(mem_addr), e_mem);
      chk(cursor == e_cur, {name, " R9 cursor"}, int'(cursor), int'(e_cur));
      chk(bus_rdata[5] == e_vb, {name, " R10 vblank flag"}, int'(bus_rdata[5]), int'(e_vb));
      chk(bus_rdata[7:6] == 2'b00, {name, " R3 status top bits"}, int'(bus_rdata[7:6]), 0);
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(bus_rdata == 8'h00, "R11 index and status after reset", int'(bus_rdata), 0);
    for (int i = 0; i < 16; i++) begin
      read_reg(i, v);
      chk(v == 0, "R11 register after reset", v, 0);
    end

    for (int i = 0; i < 16; i++) write_reg(i, (i * 37 + 5) & 255);
    for (int i = 0; i < 16; i++) begin
      read_reg(i, v);
      chk(v == ((i * 37 + 5) & 255), "R1 register readback", v, (i * 37 + 5) & 255);
    end
    foreach (cr[i]) cr[i] = 0;
    for (int k = 0; k < 3; k++) begin
      int ix;
      ix = (k == 0) ? 16 : (k == 1) ? 17 : 25;
      write_reg(ix, 8'hA5);
      read_reg(ix, v);
      chk(v == 0, "R2 unstored index reads zero", v, 0);
    end
    read_reg(3, v);
    chk(v == ((3 * 37 + 5) & 255), "R2 write to unstored index left reg3", v, (3 * 37 + 5) & 255);

    bus_write(1'b0, 8'hE5);
    @(negedge clk);
    bus_sel = 1'b0;
    #1;
    chk(bus_rdata[4:0] == 5'd5, "R1 index keeps five bits", int'(bus_rdata[4:0]), 5);
    chk(bus_rdata[7:6] == 2'b00, "R3 status top bits", int'(bus_rdata[7:6]), 0);

    cr = '{9, 5, 7, 8'h32, 3, 2, 2, 3, 0, 2, 1, 1, 8'h3F, 8'hFE, 8'h00, 8'h06};
    sweep("cfgA");
    cr = '{20, 15, 10, 8'h00, 9, 0, 7, 8, 0, 1, 0, 1, 8'h01, 8'h00, 8'h01, 8'h2F};
    sweep("cfgB");
    cr = '{7, 7, 6, 8'h1F, 1, 5, 1, 0, 0, 0, 0, 0, 8'h00, 8'h10, 8'h00, 8'h1B};
    sweep("cfgC");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule